// File: doc/BRIEF.md
# Frame-Synchronised Ping-Pong Buffer Selector

This block steers a camera-capture DMA writer between two frame buffers. It counts the pixel words the writer accepts and turns that count into a byte address inside the active buffer. It also decides when the writer moves over to the other buffer. The frame size is the product of a line width in words and a line count. Both base addresses can be programmed, but a new value reaches the writer only when the block next changes buffer, so a frame is never split across two addresses.

Three mode controls set the behaviour:
- **Swap enable.** With swap enable low, the writer stays on buffer 0 and restarts at its base on every start of frame.
- **Completion swapping.** With swap enable high and the start-of-frame select low, the buffer changes after every full frame's worth of words. Start-of-frame pulses are then ignored, so a short frame leaves every later frame misaligned.
- **Start-of-frame swapping.** With the select high, the buffer changes only on a start-of-frame pulse, so capture realigns at every frame.

Surplus words beyond the frame size start again at the base of the same buffer, so they overwrite it and never run past its end. Each change of buffer produces a one-cycle done pulse that names the buffer just left, so software can refill that base address. An optional error pulse flags a frame that was cut short.

Top module: `fbs_pingpong_sel`

## Requirements
- R1: After reset, buffer select is 0, done and error are low, and words are not accepted (`wr_vld_o` low) until the first start-of-frame pulse. That first pulse starts buffer 0 at its base, with no done pulse.
- R2: For every accepted word, `wr_addr_o` equals the active base plus the word count times WORD_BYTES (8 by default). The word count starts at 0 on every buffer change or restart.
- R3: In completion mode (swap enable 1, select 0), accepting the word whose count equals width*height-1 switches the buffer, and the next word goes to the other base at offset 0. After the first pulse, start-of-frame pulses change neither the buffer nor the count.
- R4: In start-of-frame mode (swap enable 1, select 1), every start-of-frame pulse after the first switches the buffer and restarts the count at 0 at the other base.
- R5: In start-of-frame mode and in hold mode, the word after count width*height-1 is written at offset 0 of the same buffer, with no buffer change.
- R6: `done_o` pulses for exactly one cycle, in the cycle the select changes on a swap, and `done_id_o` then holds the buffer that was left (0 or 1). `done_o` is never high otherwise.
- R7: In start-of-frame mode with error enable 1, `err_o` pulses together with the swap if fewer than width*height words were accepted since the previous start of frame. It stays low if the frame was complete, including when the final word arrives in the same cycle as the pulse, and it stays low when error enable is 0.
- R8: With swap enable 0, each start-of-frame pulse forces select 0 and restarts at the base of buffer 0, with no done pulse.
- R9: The base inputs are sampled only when a buffer change or restart occurs. A change made mid-frame leaves the addresses of the current frame unchanged.
- R10: A word accepted in the same cycle as a start-of-frame pulse is written at the address in use before the pulse. The following word starts the new frame at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| word_vld_i | input | 1 | Pixel word offered to the writer |
| swap_en_i | input | 1 | Enable buffer alternation |
| swap_on_sof_i | input | 1 | 1: swap on start of frame, 0: swap on completed frame |
| err_en_i | input | 1 | Enable short-frame error pulse |
| base0_i | input | ADDR_W | Base address of buffer 0 |
| base1_i | input | ADDR_W | Base address of buffer 1 |
| width_i | input | WIDTH_W | Words per line |
| height_i | input | HEIGHT_W | Lines per frame |
| wr_vld_o | output | 1 | Word accepted this cycle |
| wr_addr_o | output | ADDR_W | Byte address for the word |
| buf_sel_o | output | 1 | Active buffer |
| done_o | output | 1 | Buffer-left pulse |
| done_id_o | output | 1 | Buffer that was left |
| err_o | output | 1 | Short-frame error pulse |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 12-bit width and height fields, and 8-byte words. The 8-byte word size selects the shift form of the address generator. The frame size is set at run time to 4 words by 3 lines, which brings the frame boundary within a dozen cycles. Wrap-around, misalignment after a short frame in completion mode, and the coincidence of the last word with a start-of-frame pulse can therefore all be reached in short directed sequences.

// File: rtl/fbs_pkg.sv
// Package: shared mode encoding for the ping-pong buffer selector.
// Assumes: nothing; pure type definitions.
package fbs_pkg;

    // Buffer alternation policy decoded from the two mode inputs.
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,  // stay on buffer 0
        MODE_ON_DONE = 2'd1,  // swap after a full frame of words
        MODE_ON_SOF  = 2'd2   // swap on start of frame only
    } swap_mode_e;

    function automatic swap_mode_e decode_mode(input logic swap_en, input logic on_sof);
        if (!swap_en) return MODE_HOLD;
        else if (on_sof) return MODE_ON_SOF;
        else return MODE_ON_DONE;
    endfunction

endpackage

// File: rtl/fbs_frame_size.sv
// Module: fbs_frame_size
// Computes the index of the last word of a frame from the line width and
// line count.
// Assumes: width and height are non-zero and static during capture.
module fbs_frame_size #(
    parameter int WIDTH_W  = 12,
    parameter int HEIGHT_W = 12,
    parameter int CNT_W    = WIDTH_W + HEIGHT_W
) (
    input  logic [WIDTH_W-1:0]  width_i,
    input  logic [HEIGHT_W-1:0] height_i,
    output logic [CNT_W-1:0]    last_idx_o
);

    logic [CNT_W-1:0] words;

    // Word total of one frame and the index of its final word.
    always_comb begin
        words      = CNT_W'(width_i) * CNT_W'(height_i);
        last_idx_o = words - CNT_W'(1);
    end

endmodule

// File: rtl/fbs_word_counter.sv
// Module: fbs_word_counter
// Counts accepted words within the current transfer. The count returns to 0
// on a restart, and wraps to 0 after the last word of a frame.
// Assumes: restart has priority over counting; a word accepted in a restart
// cycle belongs to the previous transfer.
module fbs_word_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] last_idx_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    // Flags the word that completes one frame's worth of data.
    always_comb begin
        wrap_o = accept_i && (cnt_o == last_idx_i);
    end

    // Advances, wraps or restarts the word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (restart_i || wrap_o) begin
            cnt_o <= '0;
        end else if (accept_i) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fbs_swap_ctrl.sv
// Module: fbs_swap_ctrl
// Owns the buffer select and the latched base address. Raises done and
// error pulses, and tells the counter when to restart.
// Assumes: wrap_i only asserts while the frame is live (words are gated).
module fbs_swap_ctrl
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              wrap_i,
    input  swap_mode_e        mode_i,
    input  logic              err_en_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    output logic              restart_o,
    output logic              live_o,
    output logic              sel_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              done_o,
    output logic              done_id_o,
    output logic              err_o
);

    logic filled;
    logic start_evt;
    logic hold_evt;
    logic swap_evt;

    // Classifies this cycle's event: first start, hold restart or swap.
    always_comb begin
        start_evt = sof_i && !live_o;
        hold_evt  = sof_i && live_o && (mode_i == MODE_HOLD);
        swap_evt  = live_o && ((sof_i && (mode_i == MODE_ON_SOF)) ||
                               (wrap_i && (mode_i == MODE_ON_DONE)));
        restart_o = start_evt || hold_evt || swap_evt;
    end

    // Records whether the current frame reached its full word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled <= 1'b0;
        end else if (sof_i) begin
            filled <= 1'b0;
        end else if (wrap_i) begin
            filled <= 1'b1;
        end
    end

    // Updates select, latched base and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_o    <= 1'b0;
            sel_o     <= 1'b0;
            base_o    <= '0;
            done_o    <= 1'b0;
            done_id_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            if (start_evt || hold_evt) begin
                live_o <= 1'b1;
                sel_o  <= 1'b0;
                base_o <= base0_i;
            end else if (swap_evt) begin
                sel_o     <= ~sel_o;
                base_o    <= sel_o ? base0_i : base1_i;
                done_o    <= 1'b1;
                done_id_o <= sel_o;
                err_o     <= sof_i && (mode_i == MODE_ON_SOF) && err_en_i &&
                             !(filled || wrap_i);
            end
        end
    end

endmodule

// File: rtl/fbs_addr_gen.sv
// Module: fbs_addr_gen
// Forms the byte address from the latched base and the word count. A shift
// is used when the word size is a power of two, a multiply otherwise.
// Assumes: CNT_W <= ADDR_W.
module fbs_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 24,
    parameter int WORD_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam bit IS_POW2 = ((WORD_BYTES & (WORD_BYTES - 1)) == 0);
    localparam int SHIFT   = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] offset;

    generate
        if (IS_POW2) begin : g_shift
            // Byte offset by shifting the count.
            always_comb offset = ADDR_W'(cnt_i) << SHIFT;
        end else begin : g_mul
            // Byte offset by multiplying the count.
            always_comb offset = ADDR_W'(cnt_i) * ADDR_W'(WORD_BYTES);
        end
    endgenerate

    // Final write address.
    always_comb addr_o = base_i + offset;

endmodule

// File: rtl/fbs_pingpong_sel.sv
// Module: fbs_pingpong_sel (top)
// Selects between two frame buffers for a capture writer and generates the
// per-word write address. Three policies: hold, swap on completion, swap on
// start of frame.
// Assumes: frame size non-zero; mode inputs change only between frames.
module fbs_pingpong_sel
    import fbs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WIDTH_W    = 12,
    parameter int HEIGHT_W   = 12,
    parameter int WORD_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                word_vld_i,
    input  logic                swap_en_i,
    input  logic                swap_on_sof_i,
    input  logic                err_en_i,
    input  logic [ADDR_W-1:0]   base0_i,
    input  logic [ADDR_W-1:0]   base1_i,
    input  logic [WIDTH_W-1:0]  width_i,
    input  logic [HEIGHT_W-1:0] height_i,
    output logic                wr_vld_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic                buf_sel_o,
    output logic                done_o,
    output logic                done_id_o,
    output logic                err_o
);

    localparam int CNT_W = WIDTH_W + HEIGHT_W;

    swap_mode_e        mode;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  word_cnt;
    logic              wrap;
    logic              restart;
    logic              frame_live;
    logic [ADDR_W-1:0] active_base;

    // Mode decode and word acceptance gate.
    always_comb begin
        mode     = decode_mode(swap_en_i, swap_on_sof_i);
        wr_vld_o = word_vld_i && frame_live;
    end

    fbs_frame_size #(
        .WIDTH_W (WIDTH_W),
        .HEIGHT_W(HEIGHT_W),
        .CNT_W   (CNT_W)
    ) u_size (
        .width_i   (width_i),
        .height_i  (height_i),
        .last_idx_o(last_idx)
    );

    fbs_word_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (wr_vld_o),
        .restart_i (restart),
        .last_idx_i(last_idx),
        .cnt_o     (word_cnt),
        .wrap_o    (wrap)
    );

    fbs_swap_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_i    (sof_i),
        .wrap_i   (wrap),
        .mode_i   (mode),
        .err_en_i (err_en_i),
        .base0_i  (base0_i),
        .base1_i  (base1_i),
        .restart_o(restart),
        .live_o   (frame_live),
        .sel_o    (buf_sel_o),
        .base_o   (active_base),
        .done_o   (done_o),
        .done_id_o(done_id_o),
        .err_o    (err_o)
    );

    fbs_addr_gen #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_addr (
        .base_i(active_base),
        .cnt_i (word_cnt),
        .addr_o(wr_addr_o)
    );

endmodule

// File: rtl/fbs_pingpong_sel_chk.sv
// Module: fbs_pingpong_sel_chk
// Temporal checks on the selector, attached to every instance by bind.
// Assumes: reset is asserted from time zero.
module fbs_pingpong_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic sof_i,
    input logic swap_en_i,
    input logic swap_on_sof_i,
    input logic err_en_i,
    input logic frame_live,
    input logic buf_sel_o,
    input logic done_o,
    input logic done_id_o,
    input logic err_o
);

    // R1: the first cycle out of reset is clean.
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!buf_sel_o && !done_o && !err_o && !frame_live));

    // R3: in completion mode a live start of frame without a word never swaps.
    a_r3_sof_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sof_i && frame_live && swap_en_i && !swap_on_sof_i) && !done_o
        |-> $stable(buf_sel_o));

    // R4: in start-of-frame mode a live pulse swaps and signals done.
    a_r4_sof_swaps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sof_i && frame_live && swap_en_i && swap_on_sof_i)
        |-> (done_o && (buf_sel_o != $past(buf_sel_o))));

    // R6: done marks a select change and names the buffer left.
    a_r6_done_flip: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((buf_sel_o != $past(buf_sel_o)) && (done_id_o == $past(buf_sel_o))));

    // R7: error only follows an enabled start-of-frame-mode pulse.
    a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(sof_i && err_en_i && swap_en_i && swap_on_sof_i));

    // R8: hold mode pulse forces buffer 0 with no done.
    a_r8_hold_buf0: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sof_i && !swap_en_i) |-> (!buf_sel_o && !done_o));

endmodule

bind fbs_pingpong_sel fbs_pingpong_sel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_i        (sof_i),
    .swap_en_i    (swap_en_i),
    .swap_on_sof_i(swap_on_sof_i),
    .err_en_i     (err_en_i),
    .frame_live   (frame_live),
    .buf_sel_o    (buf_sel_o),
    .done_o       (done_o),
    .done_id_o    (done_id_o),
    .err_o        (err_o)
);

// File: tb/tb_fbs_pingpong_sel.sv
`timescale 1ns/1ps
module tb_fbs_pingpong_sel;

    localparam int AW = 32;
    localparam logic [AW-1:0] B0 = 32'h0000_1000;
    localparam logic [AW-1:0] B1 = 32'h0000_8000;
    localparam int FW = 12;  // 4 words x 3 lines

    // Table: {err_en, nwords[6:0], pad[4:0], exp_sel, exp_done_id, exp_err}
    localparam logic [15:0] VECS [6] = '{
        {1'b1, 7'd12, 5'd0, 1'b1, 1'b0, 1'b0},
        {1'b1, 7'd7,  5'd0, 1'b0, 1'b1, 1'b1},
        {1'b1, 7'd15, 5'd0, 1'b1, 1'b0, 1'b0},
        {1'b1, 7'd0,  5'd0, 1'b0, 1'b1, 1'b1},
        {1'b0, 7'd3,  5'd0, 1'b1, 1'b0, 1'b0},
        {1'b1, 7'd12, 5'd0, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_i = 1'b0, word_vld_i = 1'b0;
    logic swap_en_i = 1'b1, swap_on_sof_i = 1'b1, err_en_i = 1'b1;
    logic [AW-1:0] base0_i = B0, base1_i = B1;
    logic [11:0] width_i = 12'd4, height_i = 12'd3;
    logic wr_vld_o, buf_sel_o, done_o, done_id_o, err_o;
    logic [AW-1:0] wr_addr_o;

    int total = 0, bad = 0;
    logic cap_vld;
    logic [AW-1:0] cap_addr;
    logic [AW-1:0] bsel;
    logic cur_sel;

    always #2.5 clk = ~clk;

    fbs_pingpong_sel dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .word_vld_i(word_vld_i),
        .swap_en_i(swap_en_i), .swap_on_sof_i(swap_on_sof_i), .err_en_i(err_en_i),
        .base0_i(base0_i), .base1_i(base1_i), .width_i(width_i), .height_i(height_i),
        .wr_vld_o(wr_vld_o), .wr_addr_o(wr_addr_o), .buf_sel_o(buf_sel_o),
        .done_o(done_o), .done_id_o(done_id_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive, capture combinational address, then pass the edge.
    task automatic cyc(input logic s, input logic v);
        sof_i = s; word_vld_i = v;
        #1;
        cap_vld = wr_vld_o; cap_addr = wr_addr_o;
        @(posedge clk); #1;
        sof_i = 1'b0; word_vld_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state and no acceptance before the first start of frame
        chk("R1 sel", buf_sel_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", err_o, 0);
        cyc(0, 1);
        chk("R1 no write before sof", cap_vld, 0);
        cyc(1, 0);
        chk("R1 first sof buffer0", buf_sel_o, 0);
        chk("R1 first sof no done", done_o, 0);

        // Table walk in start-of-frame mode: R2 R4 R5 R6 R7
        cur_sel = 1'b0;
        for (int e = 0; e < 6; e++) begin
            err_en_i = VECS[e][15];
            bsel = cur_sel ? B1 : B0;
            for (int k = 0; k < int'(VECS[e][14:8]); k++) begin
                cyc(0, 1);
                if (k >= FW) chk("R5 wrap addr", cap_addr, bsel + AW'((k % FW) * 8));
                else         chk("R2 addr", cap_addr, bsel + AW'(k * 8));
                chk("R6 no done mid frame", done_o, 0);
            end
            cyc(1, 0);
            chk("R4 sel after sof", buf_sel_o, VECS[e][2]);
            chk("R6 done", done_o, 1);
            chk("R6 done id", done_id_o, VECS[e][1]);
            chk("R7 err", err_o, VECS[e][0]);
            cyc(0, 0);
            chk("R6 done one cycle", done_o, 0);
            cur_sel = VECS[e][2];
        end
        err_en_i = 1'b1;

        // R10: word coincident with sof uses the old address (sel 0 now)
        cyc(0, 1); cyc(0, 1);
        cyc(1, 1);
        chk("R10 old addr", cap_addr, B0 + 32'd16);
        chk("R10 swap", buf_sel_o, 1);
        cyc(0, 1);
        chk("R10 new frame offset0", cap_addr, B1);
        cyc(1, 0);  // short frame, back to buffer 0

        // R7: last word together with sof raises no error
        for (int k = 0; k < FW - 1; k++) cyc(0, 1);
        cyc(1, 1);
        chk("R7 last word with sof addr", cap_addr, B0 + 32'd88);
        chk("R7 no err complete", err_o, 0);
        chk("R7 swap done", done_o, 1);

        // R9: base change mid-frame (now on buffer 1)
        cyc(0, 1);
        chk("R9 addr before change", cap_addr, B1);
        base1_i = 32'h0000_9000;
        base0_i = 32'h0000_2000;
        cyc(0, 1);
        chk("R9 base not resampled", cap_addr, B1 + 32'd8);
        cyc(1, 0);
        cyc(0, 1);
        chk("R9 new base at swap", cap_addr, 32'h0000_2000);
        base0_i = B0; base1_i = B1;

        // R3: completion mode
        do_reset();
        swap_on_sof_i = 1'b0;
        cyc(1, 0);
        for (int k = 0; k < FW; k++) cyc(0, 1);
        chk("R3 last addr", cap_addr, B0 + 32'd88);
        chk("R3 swap on completion", buf_sel_o, 1);
        chk("R6 done id completion", done_id_o, 0);
        for (int k = 0; k < 5; k++) cyc(0, 1);
        chk("R3 next buffer", cap_addr, B1 + 32'd32);
        cyc(1, 0);
        chk("R3 sof ignored sel", buf_sel_o, 1);
        chk("R3 sof ignored done", done_o, 0);
        cyc(0, 1);
        chk("R3 count continues", cap_addr, B1 + 32'd40);
        for (int k = 0; k < 6; k++) cyc(0, 1);
        chk("R3 misaligned swap", buf_sel_o, 0);
        chk("R6 done id 1", done_id_o, 1);

        // R8: hold mode from buffer 1
        for (int k = 0; k < FW; k++) cyc(0, 1);
        chk("R3 on buffer1", buf_sel_o, 1);
        swap_en_i = 1'b0;
        cyc(1, 0);
        chk("R8 sel forced 0", buf_sel_o, 0);
        chk("R8 no done", done_o, 0);
        for (int k = 0; k < FW + 1; k++) begin
            cyc(0, 1);
            chk("R8 no done hold", done_o, 0);
        end
        chk("R5 hold wrap addr", cap_addr, B0);
        chk("R8 still buffer0", buf_sel_o, 0);
        cyc(1, 0);
        cyc(0, 1);
        chk("R8 restart at base0", cap_addr, B0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule